// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a direct-mapped data cache whose evicted lines are not thrown away but parked in a small fully associative side buffer. Each address maps to exactly one frame of the main array. When a request misses there, the side buffer is searched by full line address before memory is touched. A hit in the side buffer exchanges the two lines: the requested line moves into its frame, and the line it pushes out takes the freed buffer slot. The request is answered one cycle later than a normal hit and is flagged as slow. Only a miss in both structures issues a line fill to memory.

The CPU holds a request (address, read/write, write data) until the block answers with a one-cycle ready pulse. A plain hit is answered in the cycle the request is presented. On the memory side there are two independent request/acknowledge channels that move whole lines: one fills lines and one writes lines back. The side buffer is replaced in insertion order. When the slot about to be overwritten holds modified data, that line is written back first. Writes allocate on a miss. A flush input, or reset, invalidates every line in both structures.

Top module: `dmvc_cache`

## Requirements
- R1: A read whose line is valid in its main frame with a matching tag gets `cpu_ready` in the same cycle the request is first presented, with `cpu_slow` low, the addressed word on `cpu_rdata` and no memory request. Addresses are word addresses: the low log2(LINE_WORDS) bits pick the word, the next log2(SETS) bits pick the frame, and the rest form the tag.
- R2: A write that hits updates only the addressed word, and a later read of that word returns the written value.
- R3: A request that misses the main array but matches a side-buffer entry is answered one cycle after it is presented, with `cpu_slow` high, the correct word (write data merged for writes), and no fill or writeback.
- R4: After a side-buffer hit, the requested line sits in its main frame, so the next access to it is a plain hit. The line it displaced sits in the side buffer, modified data included, so an access to that line is a slow hit.
- R5: A miss in both structures raises exactly one fill request whose `mem_fill_addr` is the request's line address (the address without its word bits). The request is answered after the acknowledge, with `cpu_slow` low. A write miss allocates the line and merges the write. In `mem_fill_data` and `mem_wb_data`, word k of a line occupies bits [k*DATA_W +: DATA_W].
- R6: Every valid line displaced from the main array by a fill is inserted into the side buffer.
- R7: The side buffer has VB_ENTRIES slots (4 by default) and overwrites the entry inserted earliest. A line that has been pushed out of it costs a memory fill on its next access.
- R8: Before a fill overwrites a modified side-buffer entry, that entry is written back once on the writeback channel, with its line address and its data. A clean entry is overwritten without a writeback.
- R9: A flush pulse (or reset) invalidates all lines in both structures. Every access afterwards misses to memory, and modified data still held at the flush is dropped.
- R10: A memory request stays asserted with a stable address until its acknowledge, and fill and writeback requests are never asserted together.
- R11: During reset, `cpu_ready`, `cpu_slow`, `mem_fill_req` and `mem_wb_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate everything; taken when no miss is in progress |
| cpu_req | input | 1 | Request present, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | One-cycle answer to the held request |
| cpu_rdata | output | DATA_W | Read word, valid with `cpu_ready` |
| cpu_slow | output | 1 | Answer came from the side buffer |
| mem_fill_req | output | 1 | Line fill request |
| mem_fill_addr | output | ADDR_W-log2(LINE_WORDS) | Line address to fill |
| mem_fill_ack | input | 1 | Fill data present this cycle |
| mem_fill_data | input | DATA_W*LINE_WORDS | Fill line |
| mem_wb_req | output | 1 | Line writeback request |
| mem_wb_addr | output | ADDR_W-log2(LINE_WORDS) | Line address written back |
| mem_wb_data | output | DATA_W*LINE_WORDS | Line written back |
| mem_wb_ack | input | 1 | Writeback accepted this cycle |

## Verification
The assertions assume that the CPU keeps `cpu_req`, its address, its data and its direction unchanged until `cpu_ready`. They also assume that memory raises each acknowledge only while the matching request is up, and for one cycle. The bench drives every request from a task that holds all fields until it has seen the ready pulse and drops the request only after the following edge. Its memory responder acknowledges only a request it has observed, after a fixed two-cycle wait, for a single cycle. Flush is pulsed only while no request is pending.

// File: rtl/dmvc_pkg.sv
package dmvc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SWAP = 2'd1,
      ST_WB   = 2'd2,
      ST_FILL = 2'd3
   } dmvc_state_e;
endpackage

// File: rtl/dmvc_frame_store.sv
module dmvc_frame_store #(
   parameter int SETS   = 8,
   parameter int TAG_W  = 7,
   parameter int LINE_W = 128
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear,
   input  logic [$clog2(SETS)-1:0]  rd_idx,
   output logic                     rd_valid,
   output logic                     rd_dirty,
   output logic [TAG_W-1:0]         rd_tag,
   output logic [LINE_W-1:0]        rd_line,
   input  logic                     wr_en,
   input  logic [$clog2(SETS)-1:0]  wr_idx,
   input  logic [TAG_W-1:0]         wr_tag,
   input  logic [LINE_W-1:0]        wr_line,
   input  logic                     wr_dirty
);
   logic [SETS-1:0]   valid_q;
   logic [SETS-1:0]   dirty_q;
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [LINE_W-1:0] line_q [SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (clear) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
         dirty_q[wr_idx] <= wr_dirty;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_tag;
         line_q[wr_idx] <= wr_line;
      end
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_dirty = dirty_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_line  = line_q[rd_idx];
endmodule

// File: rtl/dmvc_victim_buf.sv
module dmvc_victim_buf #(
   parameter int ENTRIES = 4,
   parameter int LA_W    = 10,
   parameter int LINE_W  = 128
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clear,
   input  logic [LA_W-1:0]              look_la,
   output logic                         hit,
   output logic [$clog2(ENTRIES)-1:0]   hit_slot,
   output logic [LINE_W-1:0]            hit_line,
   output logic                         hit_dirty,
   output logic [$clog2(ENTRIES)-1:0]   old_slot,
   output logic                         old_valid,
   output logic                         old_dirty,
   output logic [LA_W-1:0]              old_la,
   output logic [LINE_W-1:0]            old_line,
   input  logic                         wr_en,
   input  logic [$clog2(ENTRIES)-1:0]   wr_slot,
   input  logic [LA_W-1:0]              wr_la,
   input  logic [LINE_W-1:0]            wr_line,
   input  logic                         wr_dirty,
   input  logic                         adv
);
   localparam int SLOT_W = $clog2(ENTRIES);

   logic [ENTRIES-1:0] valid_q;
   logic [ENTRIES-1:0] dirty_q;
   logic [LA_W-1:0]    la_q   [ENTRIES];
   logic [LINE_W-1:0]  line_q [ENTRIES];
   logic [SLOT_W-1:0]  ins_q;
   logic [ENTRIES-1:0] match;

   // parallel compare, one comparator per slot
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = valid_q[g] && (la_q[g] == look_la);
   end

   always_comb begin
      hit_slot = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match[i]) hit_slot = SLOT_W'(i);
      end
   end

   assign hit       = |match;
   assign hit_line  = line_q[hit_slot];
   assign hit_dirty = dirty_q[hit_slot];
   assign old_slot  = ins_q;
   assign old_valid = valid_q[ins_q];
   assign old_dirty = dirty_q[ins_q];
   assign old_la    = la_q[ins_q];
   assign old_line  = line_q[ins_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
         ins_q   <= '0;
      end else if (clear) begin
         valid_q <= '0;
         dirty_q <= '0;
         ins_q   <= '0;
      end else begin
         if (wr_en) begin
            valid_q[wr_slot] <= 1'b1;
            dirty_q[wr_slot] <= wr_dirty;
         end
         if (adv) ins_q <= ins_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         la_q[wr_slot]   <= wr_la;
         line_q[wr_slot] <= wr_line;
      end
   end
endmodule

// File: rtl/dmvc_word_merge.sv
module dmvc_word_merge #(
   parameter int DATA_W = 32,
   parameter int WORDS  = 4
) (
   input  logic [DATA_W*WORDS-1:0]    line_in,
   input  logic [$clog2(WORDS)-1:0]   sel,
   input  logic [DATA_W-1:0]          wdata,
   input  logic                       en,
   output logic [DATA_W*WORDS-1:0]    line_out,
   output logic [DATA_W-1:0]          word_out
);
   localparam int SEL_W = $clog2(WORDS);

   for (genvar g = 0; g < WORDS; g++) begin : g_word
      assign line_out[g*DATA_W +: DATA_W] =
         (en && sel == SEL_W'(g)) ? wdata : line_in[g*DATA_W +: DATA_W];
   end

   assign word_out = line_in[sel*DATA_W +: DATA_W];
endmodule

// File: rtl/dmvc_cache.sv
module dmvc_cache #(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 32,
   parameter int LINE_WORDS = 4,
   parameter int SETS       = 8,
   parameter int VB_ENTRIES = 4
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic                                          flush,
   input  logic                                          cpu_req,
   input  logic                                          cpu_we,
   input  logic [ADDR_W-1:0]                             cpu_addr,
   input  logic [DATA_W-1:0]                             cpu_wdata,
   output logic                                          cpu_ready,
   output logic [DATA_W-1:0]                             cpu_rdata,
   output logic                                          cpu_slow,
   output logic                                          mem_fill_req,
   output logic [ADDR_W-$clog2(LINE_WORDS)-1:0]          mem_fill_addr,
   input  logic                                          mem_fill_ack,
   input  logic [DATA_W*LINE_WORDS-1:0]                  mem_fill_data,
   output logic                                          mem_wb_req,
   output logic [ADDR_W-$clog2(LINE_WORDS)-1:0]          mem_wb_addr,
   output logic [DATA_W*LINE_WORDS-1:0]                  mem_wb_data,
   input  logic                                          mem_wb_ack
);
   import dmvc_pkg::*;

   localparam int OFS_W  = $clog2(LINE_WORDS);
   localparam int IDX_W  = $clog2(SETS);
   localparam int TAG_W  = ADDR_W - OFS_W - IDX_W;
   localparam int LA_W   = ADDR_W - OFS_W;
   localparam int LINE_W = DATA_W * LINE_WORDS;
   localparam int SLOT_W = $clog2(VB_ENTRIES);

   // elaboration-time parameter checks
   if (LINE_WORDS < 2 || (1 << OFS_W) != LINE_WORDS) begin : g_bad_words
      $error("LINE_WORDS must be a power of two of at least 2");
   end
   if (SETS < 2 || (1 << IDX_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (VB_ENTRIES < 2 || (1 << SLOT_W) != VB_ENTRIES) begin : g_bad_vb
      $error("VB_ENTRIES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W leaves no tag bits");
   end

   logic [OFS_W-1:0] a_ofs;
   logic [IDX_W-1:0] a_idx;
   logic [TAG_W-1:0] a_tag;
   logic [LA_W-1:0]  a_la;

   assign a_ofs = cpu_addr[OFS_W-1:0];
   assign a_idx = cpu_addr[OFS_W +: IDX_W];
   assign a_tag = cpu_addr[ADDR_W-1 -: TAG_W];
   assign a_la  = cpu_addr[ADDR_W-1:OFS_W];

   dmvc_state_e state_q, state_d;
   logic clear_go;

   // main array
   logic              fs_valid, fs_dirty, fs_we, fs_wdirty;
   logic [TAG_W-1:0]  fs_tag;
   logic [LINE_W-1:0] fs_line, fs_wline;

   // victim buffer
   logic              vb_hit, vb_hit_dirty, vb_old_valid, vb_old_dirty;
   logic [SLOT_W-1:0] vb_hit_slot, vb_old_slot, vb_wslot;
   logic [LINE_W-1:0] vb_hit_line, vb_old_line;
   logic [LA_W-1:0]   vb_old_la;
   logic              vb_we, vb_adv;

   // merge
   logic [LINE_W-1:0] mg_base, mg_line;
   logic [DATA_W-1:0] mg_word;

   logic main_hit;
   assign main_hit = fs_valid && (fs_tag == a_tag);
   assign clear_go = flush && (state_q == ST_IDLE);

   dmvc_frame_store #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_frames (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear_go),
      .rd_idx   (a_idx),
      .rd_valid (fs_valid),
      .rd_dirty (fs_dirty),
      .rd_tag   (fs_tag),
      .rd_line  (fs_line),
      .wr_en    (fs_we),
      .wr_idx   (a_idx),
      .wr_tag   (a_tag),
      .wr_line  (fs_wline),
      .wr_dirty (fs_wdirty)
   );

   dmvc_victim_buf #(.ENTRIES(VB_ENTRIES), .LA_W(LA_W), .LINE_W(LINE_W)) u_victims (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear_go),
      .look_la   (a_la),
      .hit       (vb_hit),
      .hit_slot  (vb_hit_slot),
      .hit_line  (vb_hit_line),
      .hit_dirty (vb_hit_dirty),
      .old_slot  (vb_old_slot),
      .old_valid (vb_old_valid),
      .old_dirty (vb_old_dirty),
      .old_la    (vb_old_la),
      .old_line  (vb_old_line),
      .wr_en     (vb_we),
      .wr_slot   (vb_wslot),
      .wr_la     ({fs_tag, a_idx}),
      .wr_line   (fs_line),
      .wr_dirty  (fs_dirty),
      .adv       (vb_adv)
   );

   assign mg_base = (state_q == ST_SWAP) ? vb_hit_line : fs_line;

   dmvc_word_merge #(.DATA_W(DATA_W), .WORDS(LINE_WORDS)) u_merge (
      .line_in  (mg_base),
      .sel      (a_ofs),
      .wdata    (cpu_wdata),
      .en       (cpu_we),
      .line_out (mg_line),
      .word_out (mg_word)
   );

   always_comb begin
      state_d   = state_q;
      cpu_ready = 1'b0;
      cpu_slow  = 1'b0;
      fs_we     = 1'b0;
      fs_wline  = mg_line;
      fs_wdirty = 1'b1;
      vb_we     = 1'b0;
      vb_wslot  = vb_old_slot;
      vb_adv    = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (!flush && cpu_req) begin
               if (main_hit) begin
                  cpu_ready = 1'b1;
                  fs_we     = cpu_we;
               end else if (vb_hit) begin
                  state_d = ST_SWAP;
               end else if (fs_valid && vb_old_valid && vb_old_dirty) begin
                  state_d = ST_WB;
               end else begin
                  state_d = ST_FILL;
               end
            end
         end
         ST_SWAP: begin
            cpu_ready = 1'b1;
            cpu_slow  = 1'b1;
            fs_we     = 1'b1;
            fs_wdirty = vb_hit_dirty | cpu_we;
            vb_we     = 1'b1;
            vb_wslot  = vb_hit_slot;
            state_d   = ST_IDLE;
         end
         ST_WB: begin
            if (mem_wb_ack) state_d = ST_FILL;
         end
         ST_FILL: begin
            if (mem_fill_ack) begin
               fs_we     = 1'b1;
               fs_wline  = mem_fill_data;
               fs_wdirty = 1'b0;
               vb_we     = fs_valid;
               vb_adv    = fs_valid;
               state_d   = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign cpu_rdata     = mg_word;
   assign mem_fill_req  = (state_q == ST_FILL);
   assign mem_fill_addr = a_la;
   assign mem_wb_req    = (state_q == ST_WB);
   assign mem_wb_addr   = vb_old_la;
   assign mem_wb_data   = vb_old_line;
endmodule

// File: rtl/dmvc_cache_chk.sv
module dmvc_cache_chk #(
   parameter int LA_W = 10
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cpu_req,
   input logic            cpu_ready,
   input logic            cpu_slow,
   input logic            mem_fill_req,
   input logic            mem_fill_ack,
   input logic [LA_W-1:0] mem_fill_addr,
   input logic            mem_wb_req,
   input logic            mem_wb_ack,
   input logic [LA_W-1:0] mem_wb_addr
);
   // R3: a slow answer is an answer
   a_r3_slow_is_ready: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_slow |-> cpu_ready);

   // R3: a slow answer follows a cycle in which the request waited
   a_r3_slow_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_slow |-> $past(cpu_req && !cpu_ready));

   // R5: no answer while a fill is outstanding
   a_r5_no_ready_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
      mem_fill_req |-> !cpu_ready);

   // R10: fill request held with a stable address until acknowledged
   a_r10_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_fill_req && !mem_fill_ack) |=> (mem_fill_req && $stable(mem_fill_addr)));

   // R10: writeback request held with a stable address until acknowledged
   a_r10_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wb_req && !mem_wb_ack) |=> (mem_wb_req && $stable(mem_wb_addr)));

   // R10: the two memory channels are never requested together
   a_r10_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_fill_req && mem_wb_req));

   // R8: a writeback is always followed by the fill it cleared the way for
   a_r8_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wb_req && mem_wb_ack) |=> mem_fill_req);
endmodule

bind dmvc_cache dmvc_cache_chk #(.LA_W(LA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cpu_req       (cpu_req),
   .cpu_ready     (cpu_ready),
   .cpu_slow      (cpu_slow),
   .mem_fill_req  (mem_fill_req),
   .mem_fill_ack  (mem_fill_ack),
   .mem_fill_addr (mem_fill_addr),
   .mem_wb_req    (mem_wb_req),
   .mem_wb_ack    (mem_wb_ack),
   .mem_wb_addr   (mem_wb_addr)
);

// File: tb/test_dmvc_cache.sv
module test_dmvc_cache;
   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush = 1'b0;
   logic          cpu_req = 1'b0;
   logic          cpu_we = 1'b0;
   logic [11:0]   cpu_addr = '0;
   logic [31:0]   cpu_wdata = '0;
   logic          cpu_ready, cpu_slow;
   logic [31:0]   cpu_rdata;
   logic          mem_fill_req, mem_wb_req;
   logic [9:0]    mem_fill_addr, mem_wb_addr;
   logic          mem_fill_ack = 1'b0;
   logic [127:0]  mem_fill_data = '0;
   logic [127:0]  mem_wb_data;
   logic          mem_wb_ack = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   dmvc_cache i_dmvc_cache (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .cpu_slow(cpu_slow),
      .mem_fill_req(mem_fill_req), .mem_fill_addr(mem_fill_addr),
      .mem_fill_ack(mem_fill_ack), .mem_fill_data(mem_fill_data),
      .mem_wb_req(mem_wb_req), .mem_wb_addr(mem_wb_addr),
      .mem_wb_data(mem_wb_data), .mem_wb_ack(mem_wb_ack)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int n_fill = 0;
   int n_wb = 0;
   logic [9:0] last_wb_la = '0;
   bit done = 1'b0;

   logic [31:0] ref_mem [int];   // architectural value of each written word
   logic [31:0] back_mem [int];  // what the memory model holds

   typedef struct {
      logic [31:0] data;
      bit          chk_data;
      bit          slow;
      int          rq;
   } exp_t;
   exp_t exp_q[$];

   function automatic logic [31:0] init_val(input int a);
      return 32'hC0DE_0000 | 32'(a);
   endfunction

   function automatic logic [31:0] ref_val(input int a);
      if (ref_mem.exists(a)) return ref_mem[a];
      return init_val(a);
   endfunction

   function automatic logic [31:0] back_val(input int a);
      if (back_mem.exists(a)) return back_mem[a];
      return init_val(a);
   endfunction

   function automatic logic [11:0] mk(input int tag, input int idx, input int ofs);
      return {7'(tag), 3'(idx), 2'(ofs)};
   endfunction

   task automatic chk(input bit ok, input int rq, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL R%0d actual=%h expected=%h at %0t", rq, act, exp, $time);
      end
   endtask

   // memory model: fill channel
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && mem_fill_req) begin
            repeat (2) @(negedge clk);
            for (int k = 0; k < 4; k++)
               mem_fill_data[k*32 +: 32] = back_val(int'({mem_fill_addr, 2'(k)}));
            mem_fill_ack = 1'b1;
            n_fill++;
            @(negedge clk);
            mem_fill_ack = 1'b0;
         end
      end
   end

   // memory model: writeback channel
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && mem_wb_req) begin
            repeat (2) @(negedge clk);
            for (int k = 0; k < 4; k++)
               back_mem[int'({mem_wb_addr, 2'(k)})] = mem_wb_data[k*32 +: 32];
            last_wb_la = mem_wb_addr;
            mem_wb_ack = 1'b1;
            n_wb++;
            @(negedge clk);
            mem_wb_ack = 1'b0;
         end
      end
   end

   // monitor: compares each answer with the oldest expected item
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && cpu_ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, 1, 32'(cpu_ready), 32'd0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               if (e.chk_data) chk(cpu_rdata == e.data, e.rq, cpu_rdata, e.data);
               chk(cpu_slow == e.slow, e.rq, 32'(cpu_slow), 32'(e.slow));
            end
         end
      end
   end

   // driver: queues the expectation, holds the request until the answer
   task automatic access(input bit we, input logic [11:0] a, input logic [31:0] wd,
                         input int rq, input bit exp_slow, input int exp_lat,
                         input int exp_fill, input int exp_wb);
      exp_t e;
      int f0, w0, lat;
      f0 = n_fill;
      w0 = n_wb;
      e.data = ref_val(int'(a));
      e.chk_data = !we;
      e.slow = exp_slow;
      e.rq = rq;
      exp_q.push_back(e);
      if (we) ref_mem[int'(a)] = wd;
      @(posedge clk); #1;
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!cpu_ready && lat < 1000);
      @(posedge clk); #1;
      cpu_req = 1'b0; cpu_we = 1'b0;
      if (exp_lat > 0) chk(lat == exp_lat, rq, 32'(lat), 32'(exp_lat));
      chk(n_fill - f0 == exp_fill, rq, 32'(n_fill - f0), 32'(exp_fill));
      chk(n_wb - w0 == exp_wb, rq, 32'(n_wb - w0), 32'(exp_wb));
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: quiet outputs during reset
      chk(!cpu_ready && !cpu_slow, 11, {cpu_ready, cpu_slow}, 0);
      chk(!mem_fill_req && !mem_wb_req, 11, {mem_fill_req, mem_wb_req}, 0);
      @(posedge clk); #1 rst_n = 1'b1;

      // R5: cold read misses both structures, one fill, fast flag
      access(0, mk(1,0,1), 0, 5, 0, 0, 1, 0);
      // R1: same line now hits in one cycle with no traffic
      access(0, mk(1,0,3), 0, 1, 0, 1, 0, 0);
      // R2: write hit, then read back
      access(1, mk(1,0,1), 32'h1111_AAAA, 2, 0, 1, 0, 0);
      access(0, mk(1,0,1), 0, 2, 0, 1, 0, 0);
      // R6: conflicting line displaces the modified line into the side buffer
      access(0, mk(2,0,0), 0, 6, 0, 0, 1, 0);
      // R3: side-buffer hit, slow, one extra cycle, modified data kept
      access(0, mk(1,0,1), 0, 3, 1, 2, 0, 0);
      // R4: swapped-in line is now a plain hit, displaced one is a slow hit
      access(0, mk(1,0,2), 0, 4, 0, 1, 0, 0);
      access(0, mk(2,0,3), 0, 4, 1, 2, 0, 0);
      // R7: three more conflicting lines fill the remaining slots, all clean
      access(0, mk(3,0,0), 0, 7, 0, 0, 1, 0);
      access(0, mk(4,0,0), 0, 7, 0, 0, 1, 0);
      access(0, mk(5,0,0), 0, 7, 0, 0, 1, 0);
      // R8: buffer full, oldest slot is the modified line: written back first
      access(0, mk(6,0,0), 0, 8, 0, 0, 1, 1);
      chk(last_wb_la == {7'd1, 3'd0}, 8, 32'(last_wb_la), 32'({7'd1, 3'd0}));
      // R7: the pushed-out line costs a fill, and memory returns its new data
      access(0, mk(1,0,1), 0, 7, 0, 0, 1, 0);
      access(0, mk(2,0,0), 0, 7, 0, 0, 1, 0);
      // R3: write through a side-buffer hit
      access(1, mk(4,0,2), 32'h2222_BBBB, 3, 1, 2, 0, 0);
      access(0, mk(4,0,2), 0, 3, 0, 1, 0, 0);
      // R4: modified line moves into the buffer and back without losing data
      access(0, mk(5,0,3), 0, 4, 1, 2, 0, 0);
      access(0, mk(4,0,2), 0, 4, 1, 2, 0, 0);
      // R5: write miss allocates, merged word reads back as a hit
      access(1, mk(9,1,0), 32'h3333_CCCC, 5, 0, 0, 1, 0);
      access(0, mk(9,1,0), 0, 5, 0, 1, 0, 0);
      access(0, mk(9,1,1), 0, 5, 0, 1, 0, 0);

      // R9: flush drops all lines; the modified word still cached is lost
      @(posedge clk); #1 flush = 1'b1;
      @(posedge clk); #1 flush = 1'b0;
      ref_mem[int'(mk(4,0,2))] = back_val(int'(mk(4,0,2)));
      ref_mem[int'(mk(9,1,0))] = back_val(int'(mk(9,1,0)));
      access(0, mk(4,0,2), 0, 9, 0, 0, 1, 0);
      access(0, mk(9,1,0), 0, 9, 0, 0, 1, 0);
      access(0, mk(5,0,3), 0, 9, 0, 0, 1, 0);

      // R10: channels idle once everything has been answered
      repeat (2) @(negedge clk);
      chk(!mem_fill_req && !mem_wb_req, 10, {mem_fill_req, mem_wb_req}, 0);
      chk(exp_q.size() == 0, 1, 32'(exp_q.size()), 0);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule